// File: doc/BRIEF.md
# Modulator Instability Flag Generator

This block turns a per-clock instability indication from an oversampling modulator into a single status flag. Its behaviour depends on a mode input. In raw mode, with no decimation filter downstream, the flag is a fixed-length pulse. The pulse fires again for as long as the fault persists. In filtered mode the flag rises as soon as the fault appears. It then stays high until a settling interval has passed with the fault absent, so that the word after the flag falls is known to be fully settled.

A single down-counter times both the pulse length and the hold interval. Both lengths are parameters. The defaults are a 3-cycle pulse and a 5,120-cycle hold, and a bench can shorten them. The mode is read only when a new pulse or hold starts. A reset with asynchronous assertion and synchronous release clears all state.

Top module: `instab_flag`

## Requirements
- R1: While reset is asserted, and after its release until an instability sample is taken, flag_o is low.
- R2: In raw mode (mode_i = 0), an edge that samples unstable_i high while the block is idle raises flag_o. flag_o then stays high for exactly PULSE_LEN cycles.
- R3: In raw mode, after each pulse flag_o is low for exactly one cycle. If unstable_i is high in that cycle, the next pulse starts at the following edge, so a persistent fault gives a period of PULSE_LEN+1 cycles.
- R4: While a raw-mode pulse is running, the level of unstable_i neither shortens nor lengthens it.
- R5: In filtered mode (mode_i = 1), an edge that samples unstable_i high while the block is idle raises flag_o at that edge.
- R6: In filtered mode, flag_o falls at the edge that samples the HOLD_LEN-th consecutive low value of unstable_i, and not before.
- R7: In filtered mode, a high sample of unstable_i during the countdown restarts it while flag_o stays high.
- R8: A change of mode_i during a pulse or a hold has no effect until that pulse or hold ends. The new mode applies to the next start.
- R9: While idle, with unstable_i sampled low, flag_o stays low in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| mode_i | input | 1 | 0 = raw modulator mode, 1 = filtered mode |
| unstable_i | input | 1 | Modulator instability indication, sampled every clock |
| flag_o | output | 1 | Instability flag |

## Verification
A corrupted counter shows at the port as a flag edge on the wrong cycle. In raw mode that error is visible within one pulse period. In filtered mode it is visible at the end of the next countdown, which is why the bench shortens HOLD_LEN. A wrong state decode shows up as a missing gap between retriggered pulses, or as a pulse that takes on hold behaviour after a mode change. Both appear within PULSE_LEN+1 cycles. Each cycle is compared against a model built from the requirements.

// File: rtl/instab_flag_pkg.sv
`timescale 1ns/1ps
package instab_flag_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_GAP   = 2'd2,
    ST_HOLD  = 2'd3
  } instab_state_e;

  function automatic int unsigned max_len(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/instab_rst_sync.sv
`timescale 1ns/1ps
module instab_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/instab_down_counter.sv
`timescale 1ns/1ps
module instab_down_counter #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = load_i | dec_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (dec_i) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

  // R6: the countdown must never wrap below zero
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i) |-> !zero_o);

endmodule

// File: rtl/instab_flag_ctrl.sv
`timescale 1ns/1ps
module instab_flag_ctrl
  import instab_flag_pkg::*;
#(
  parameter int PULSE_LEN = 3,
  parameter int HOLD_LEN  = 5120,
  parameter int CW        = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_i,
  input  logic          unstable_i,
  input  logic          cnt_zero_i,
  output logic          cnt_load_o,
  output logic [CW-1:0] cnt_load_val_o,
  output logic          cnt_dec_o,
  output logic          flag_o
);

  localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_LEN - 1);
  localparam logic [CW-1:0] HOLD_LD  = CW'(HOLD_LEN - 1);

  instab_state_e state_q, state_d;
  logic          flag_q, flag_d;
  logic          ready;

  assign ready = (state_q == ST_IDLE) || (state_q == ST_GAP);

  always_comb begin
    state_d        = state_q;
    cnt_load_o     = 1'b0;
    cnt_load_val_o = PULSE_LD;
    cnt_dec_o      = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_GAP: begin
        if (unstable_i) begin
          cnt_load_o = 1'b1;
          if (mode_i) begin
            state_d        = ST_HOLD;
            cnt_load_val_o = HOLD_LD;
          end else begin
            state_d        = ST_PULSE;
            cnt_load_val_o = PULSE_LD;
          end
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_PULSE: begin
        if (cnt_zero_i) begin
          state_d = ST_GAP;
        end else begin
          cnt_dec_o = 1'b1;
        end
      end
      ST_HOLD: begin
        if (unstable_i) begin
          cnt_load_o     = 1'b1;
          cnt_load_val_o = HOLD_LD;
        end else if (cnt_zero_i) begin
          state_d = ST_IDLE;
        end else begin
          cnt_dec_o = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    flag_d = (state_d == ST_PULSE) || (state_d == ST_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      flag_q  <= flag_d;
    end
  end

  assign flag_o = flag_q;

  a_r2_raw_start: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !mode_i && unstable_i) |=> (flag_o && state_q == ST_PULSE));

  a_r5_filt_start: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && mode_i && unstable_i) |=> (flag_o && state_q == ST_HOLD));

  a_r3_gap_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PULSE && cnt_zero_i) |=> !flag_o);

  a_r4_pulse_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PULSE && !cnt_zero_i) |=> (flag_o && state_q == ST_PULSE));

  a_r7_hold_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && unstable_i) |=> (flag_o && !cnt_zero_i));

  a_r6_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !cnt_zero_i) |=> flag_o);

  a_r8_no_cross_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PULSE) |=> (state_q != ST_HOLD));

  a_r8_no_cross_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |=> (state_q != ST_PULSE));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !unstable_i) |=> !flag_o);

endmodule

// File: rtl/instab_flag.sv
`timescale 1ns/1ps
module instab_flag
  import instab_flag_pkg::*;
#(
  parameter int PULSE_LEN = 3,
  parameter int HOLD_LEN  = 5120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic unstable_i,
  output logic flag_o
);

  localparam int unsigned LONGEST = max_len(PULSE_LEN, HOLD_LEN);
  localparam int CW = (LONGEST > 1) ? $clog2(LONGEST) : 1;

  logic          rst_sync_n;
  logic          cnt_load;
  logic [CW-1:0] cnt_load_val;
  logic          cnt_dec;
  logic          cnt_zero;

  instab_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  instab_down_counter #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (cnt_load),
    .load_val_i (cnt_load_val),
    .dec_i      (cnt_dec),
    .zero_o     (cnt_zero)
  );

  instab_flag_ctrl #(
    .PULSE_LEN (PULSE_LEN),
    .HOLD_LEN  (HOLD_LEN),
    .CW        (CW)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .mode_i         (mode_i),
    .unstable_i     (unstable_i),
    .cnt_zero_i     (cnt_zero),
    .cnt_load_o     (cnt_load),
    .cnt_load_val_o (cnt_load_val),
    .cnt_dec_o      (cnt_dec),
    .flag_o         (flag_o)
  );

  // R1: flag is low while reset is asserted
  a_r1_reset_low: assert property (@(posedge clk) !rst_n |-> !flag_o);

endmodule

// File: tb/instab_flag_test.sv
`timescale 1ns/1ps
module instab_flag_test;

  localparam int PULSE_LEN = 3;
  localparam int HOLD_LEN  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_i = 1'b0;
  logic unstable_i = 1'b0;
  logic flag_o;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 1'b0;

  // model state: 0 idle, 1 pulse, 2 gap, 3 hold
  int    m_ph = 0;
  int    m_left = 0;
  int    m_lows = 0;
  string m_tag = "R1";

  always #2.5 clk = ~clk;

  instab_flag #(.PULSE_LEN(PULSE_LEN), .HOLD_LEN(HOLD_LEN)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .unstable_i (unstable_i),
    .flag_o     (flag_o)
  );

  function automatic bit exp_flag(int ph);
    return (ph == 1) || (ph == 3);
  endfunction

  task automatic model_step(bit md, bit u);
    case (m_ph)
      0, 2: begin
        if (u) begin
          if (md) begin
            m_ph = 3; m_lows = 0; m_tag = "R5";
          end else begin
            m_tag = (m_ph == 2) ? "R3" : "R2";
            m_ph = 1; m_left = PULSE_LEN;
          end
        end else begin
          m_ph = 0; m_tag = "R9";
        end
      end
      1: begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_ph = 2; m_tag = "R3";
        end else if (md) m_tag = "R8";
        else if (u) m_tag = "R4";
        else m_tag = "R2";
      end
      default: begin
        if (u) begin
          m_lows = 0; m_tag = "R7";
        end else begin
          m_lows = m_lows + 1;
          m_tag = md ? "R6" : "R8";
          if (m_lows == HOLD_LEN) m_ph = 0;
        end
      end
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_lows = 0; m_tag = "R1";
    end else begin
      model_step(mode_i, unstable_i);
    end
  end

  task automatic compare_now();
    bit e;
    e = exp_flag(m_ph);
    compared++;
    if (flag_o !== e) begin
      mismatched++;
      $display("FAIL %s cycle %0d: flag_o=%0b expected %0b", m_tag, cycles, flag_o, e);
    end
  endtask

  task automatic cyc(bit md, bit u);
    @(negedge clk);
    compare_now();
    mode_i = md;
    unstable_i = u;
  endtask

  task automatic idle_cycles(int n, bit md);
    for (int i = 0; i < n; i++) cyc(md, 1'b0);
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: cycle count %0d expected completion", cycles);
      report();
    end
  end

  initial begin
    int unsigned seed;
    bit md, u;
    seed = $urandom(32'd20240611);
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      compare_now();
    end
    rst_n = 1'b1;
    idle_cycles(6, 1'b0);
    // R9: idle, both modes, no fault
    idle_cycles(5, 1'b1);
    // R2: single fault cycle in raw mode
    cyc(1'b0, 1'b1);
    idle_cycles(8, 1'b0);
    // R3: persistent fault in raw mode
    for (int i = 0; i < 17; i++) cyc(1'b0, 1'b1);
    idle_cycles(6, 1'b0);
    // R4: fault toggling during a pulse
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b0);
    idle_cycles(6, 1'b0);
    // R5 and R6: filtered mode hold
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1);
    idle_cycles(HOLD_LEN + 5, 1'b1);
    // R7: reassertion during countdown
    cyc(1'b1, 1'b1);
    idle_cycles(HOLD_LEN - 3, 1'b1);
    cyc(1'b1, 1'b1);
    idle_cycles(HOLD_LEN + 4, 1'b1);
    // R8: mode change during a hold and during a pulse
    cyc(1'b1, 1'b1);
    idle_cycles(HOLD_LEN + 4, 1'b0);
    cyc(1'b0, 1'b1);
    cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b1);
    cyc(1'b1, 1'b0);
    idle_cycles(HOLD_LEN + 6, 1'b1);
    // R1: reset in the middle of a hold
    cyc(1'b1, 1'b1);
    idle_cycles(4, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    compare_now();
    idle_cycles(3, 1'b1);
    rst_n = 1'b1;
    idle_cycles(5, 1'b1);
    // random mix
    md = 1'b0; u = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 48) == 0) md = ~md;
      if (($urandom % 7) == 0) u = ~u;
      cyc(md, u);
    end
    idle_cycles(HOLD_LEN + 5, md);
    done = 1'b1;
    report();
  end

endmodule